// File: doc/BRIEF.md
# Per-ID Ordering Stall Tracker

This block sits on the request-injection path of a network interface that turns memory-mapped transactions into network packets. The network does not keep responses in order across destinations. It does keep them in order between one source and one destination, because routing is static. For every transaction ID the tracker holds a count of outstanding requests and the single destination those requests went to.

A new request is let through in two cases. The first is that its ID has nothing outstanding. The second is that its destination matches the one on record and the count has not reached its configured ceiling. In every other case the request waits at the input handshake until enough responses retire. A retire pulse with an ID lowers that ID's count by one. Requests with different IDs never hold each other back. A request marked atomic skips the check and is not counted.

Each ID slot is a small state machine with three states. FREE means the count is zero. OPEN means some requests are outstanding and there is room for more. FULL means the count has reached the ceiling. The transitions are:
- FREE→OPEN on an accept. This goes straight to FULL when the ceiling is one.
- OPEN→FULL on an accept that reaches the ceiling.
- OPEN→FREE on a retire of the last request.
- FULL→OPEN on a retire, or FULL→FREE when the ceiling is one.
- An accept and a retire in the same cycle keep the state.

Top module: `ord_stall_tracker`

## Requirements
- R1: After reset every ID is free, `out_valid_o` is low while `req_valid_i` is low, and a request on any ID and destination is presented at the output.
- R2: Whether a request on one ID is admitted depends only on that ID's own outstanding count and recorded destination. A request on a free ID passes even while other IDs are stalled.
- R3: Requests with one ID to one destination pass back to back until the count for that ID reaches `CNT_MAX`.
- R4: A non-atomic request whose ID has outstanding requests to a different destination is held until that ID's count returns to zero.
- R5: A request with `req_atomic_i` high passes regardless of the tracking state and leaves the count and the recorded destination unchanged.
- R6: A non-atomic request whose ID count equals `CNT_MAX` is held even when its destination matches.
- R7: A retire pulse (`rsp_retire_i` high with `rsp_id_i`) lowers that ID's count by one. At zero the ID accepts any destination. A retire is never issued for an ID whose count is zero.
- R8: An accept and a retire on the same ID in the same cycle leave that ID's count unchanged, and the recorded destination is the accepted one.
- R9: The handshake follows these rules:
  - `out_valid_o` = `req_valid_i` AND admit.
  - `req_ready_o` = `out_ready_i` AND admit.
  - ID, destination and atomic flag pass straight through.
  - While the output is valid, not ready, and the input request is held, the output stays valid with the same payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Incoming request valid |
| req_ready_o | output | 1 | Incoming request accepted |
| req_id_i | input | ID_W | Transaction ID of the request |
| req_dst_i | input | DST_W | Destination node of the request |
| req_atomic_i | input | 1 | Request is atomic and bypasses tracking |
| out_valid_o | output | 1 | Request released to the network |
| out_ready_i | input | 1 | Network accepts the released request |
| out_id_o | output | ID_W | Transaction ID of the released request |
| out_dst_o | output | DST_W | Destination of the released request |
| out_atomic_o | output | 1 | Atomic flag of the released request |
| rsp_retire_i | input | 1 | A response for a tracked request completed |
| rsp_id_i | input | ID_W | Transaction ID of the completed response |

## Verification
The checker relies on three things about the environment:
- Retire pulses arrive only for IDs that still have non-atomic requests outstanding, and atomic responses are never retired.
- A stalled request is held unchanged by its source.
- The output-stability property applies only in cycles where the input was held.

The bench keeps a model of each ID's count and destination. It issues a retire only when the model count for that ID is nonzero, and it checks stability only with input sequences that repeat the same request.

// File: rtl/ost_pkg.sv
package ost_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_OPEN = 2'd1,
        SLOT_FULL = 2'd2
    } slot_state_e;
endpackage

// File: rtl/ost_id_slot.sv
module ost_id_slot
    import ost_pkg::*;
#(
    parameter int DST_W   = 2,
    parameter int CNT_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             drop_i,
    input  logic [DST_W-1:0] take_dst_i,
    input  logic [DST_W-1:0] ask_dst_i,
    output logic             ok_o
);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CNT_MAX - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DST_W-1:0] dst_q, dst_d;
    logic             up, down;

    assign up   = take_i & ~drop_i;
    assign down = drop_i & ~take_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        dst_d   = take_i ? take_dst_i : dst_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (take_i) begin
                    cnt_d   = cnt_q + ONE;
                    state_d = (CNT_MAX == 1) ? SLOT_FULL : SLOT_OPEN;
                end
            end
            SLOT_OPEN: begin
                if (up) begin
                    cnt_d = cnt_q + ONE;
                    if (cnt_q == LAST) state_d = SLOT_FULL;
                end else if (down) begin
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == ONE) state_d = SLOT_FREE;
                end
            end
            SLOT_FULL: begin
                if (down) begin
                    cnt_d   = cnt_q - ONE;
                    state_d = (CNT_MAX == 1) ? SLOT_FREE : SLOT_OPEN;
                end
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            cnt_q   <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dst_q   <= dst_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SLOT_FREE: ok_o = 1'b1;
            SLOT_OPEN: ok_o = (dst_q == ask_dst_i);
            SLOT_FULL: ok_o = 1'b0;
            default:   ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ost_admit.sv
module ost_admit #(
    parameter int NUM_IDS = 4,
    parameter int ID_W    = 2
) (
    input  logic [NUM_IDS-1:0] ok_vec_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic               atomic_i,
    input  logic               req_valid_i,
    input  logic               out_ready_i,
    output logic               out_valid_o,
    output logic               req_ready_o,
    output logic               take_o
);
    logic admit;

    assign admit       = atomic_i | ok_vec_i[id_i];
    assign out_valid_o = req_valid_i & admit;
    assign req_ready_o = out_ready_i & admit;
    assign take_o      = req_valid_i & out_ready_i & admit & ~atomic_i;
endmodule

// File: rtl/ord_stall_tracker.sv
module ord_stall_tracker #(
    parameter int ID_W    = 2,
    parameter int DST_W   = 2,
    parameter int CNT_MAX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [ID_W-1:0]  req_id_i,
    input  logic [DST_W-1:0] req_dst_i,
    input  logic             req_atomic_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [ID_W-1:0]  out_id_o,
    output logic [DST_W-1:0] out_dst_o,
    output logic             out_atomic_o,
    input  logic             rsp_retire_i,
    input  logic [ID_W-1:0]  rsp_id_i
);
    localparam int NUM_IDS = 1 << ID_W;

    logic [NUM_IDS-1:0] ok_vec;
    logic               take;

    ost_admit #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_admit (
        .ok_vec_i    (ok_vec),
        .id_i        (req_id_i),
        .atomic_i    (req_atomic_i),
        .req_valid_i (req_valid_i),
        .out_ready_i (out_ready_i),
        .out_valid_o (out_valid_o),
        .req_ready_o (req_ready_o),
        .take_o      (take)
    );

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
        logic take_here, drop_here;
        assign take_here = take & (req_id_i == ID_W'(g));
        assign drop_here = rsp_retire_i & (rsp_id_i == ID_W'(g));
        ost_id_slot #(.DST_W(DST_W), .CNT_MAX(CNT_MAX)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .take_i     (take_here),
            .drop_i     (drop_here),
            .take_dst_i (req_dst_i),
            .ask_dst_i  (req_dst_i),
            .ok_o       (ok_vec[g])
        );
    end

    assign out_id_o     = req_id_i;
    assign out_dst_o    = req_dst_i;
    assign out_atomic_o = req_atomic_i;
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
    parameter int ID_W    = 2,
    parameter int DST_W   = 2,
    parameter int CNT_MAX = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic [ID_W-1:0]  req_id_i,
    input logic [DST_W-1:0] req_dst_i,
    input logic             req_atomic_i,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [ID_W-1:0]  out_id_o,
    input logic [DST_W-1:0] out_dst_o,
    input logic             out_atomic_o,
    input logic             rsp_retire_i,
    input logic [ID_W-1:0]  rsp_id_i
);
    localparam int NUM_IDS = 1 << ID_W;
    localparam int SH_W    = $clog2(CNT_MAX + 2);

    logic [SH_W-1:0]  sh_cnt [NUM_IDS];
    logic [DST_W-1:0] sh_dst [NUM_IDS];
    logic             fire;

    assign fire = out_valid_o & out_ready_i & ~out_atomic_o;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_sh
        logic inc, dec;
        assign inc = fire & (out_id_o == ID_W'(g));
        assign dec = rsp_retire_i & (rsp_id_i == ID_W'(g)) & (sh_cnt[g] != '0);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_cnt[g] <= '0;
                sh_dst[g] <= '0;
            end else begin
                if (inc && !dec) sh_cnt[g] <= sh_cnt[g] + SH_W'(1);
                else if (dec && !inc) sh_cnt[g] <= sh_cnt[g] - SH_W'(1);
                if (inc) sh_dst[g] <= out_dst_o;
            end
        end
    end

    a_r7_retire_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retire_i |-> sh_cnt[rsp_id_i] != '0);

    a_r4_same_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sh_cnt[out_id_o] != '0) |-> out_dst_o == sh_dst[out_id_o]);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> sh_cnt[out_id_o] < SH_W'(CNT_MAX));

    a_r5_atomic_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_atomic_i) |-> out_valid_o);

    a_r2_free_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_atomic_i && sh_cnt[req_id_i] == '0) |-> out_valid_o);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) ##1
        (req_valid_i && $stable(req_id_i) && $stable(req_dst_i) && $stable(req_atomic_i))
        |-> out_valid_o && $stable(out_id_o) && $stable(out_dst_o));

    a_r9_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> out_ready_i);
endmodule

bind ord_stall_tracker ost_checker #(.ID_W(ID_W), .DST_W(DST_W), .CNT_MAX(CNT_MAX)) u_ost_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_id_i     (req_id_i),
    .req_dst_i    (req_dst_i),
    .req_atomic_i (req_atomic_i),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .out_id_o     (out_id_o),
    .out_dst_o    (out_dst_o),
    .out_atomic_o (out_atomic_o),
    .rsp_retire_i (rsp_retire_i),
    .rsp_id_i     (rsp_id_i)
);

// File: tb/ord_stall_tracker_bench.sv
`timescale 1ns/1ps
module ord_stall_tracker_bench;
    localparam int ID_W = 2, DST_W = 2, CNT_MAX = 3;
    localparam int NI = 1 << ID_W, ND = 1 << DST_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_ready, req_atomic = 0, out_valid, out_ready = 0, out_atomic, rsp_retire = 0;
    logic [ID_W-1:0] req_id = '0, out_id, rsp_id = '0;
    logic [DST_W-1:0] req_dst = '0, out_dst;

    int checks = 0, errors = 0;
    int mcnt [NI];
    int mdst [NI];
    bit done = 0;

    always #2.5 clk = ~clk;

    ord_stall_tracker #(.ID_W(ID_W), .DST_W(DST_W), .CNT_MAX(CNT_MAX)) u_ord_stall_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_id_i(req_id), .req_dst_i(req_dst), .req_atomic_i(req_atomic),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_id_o(out_id),
        .out_dst_o(out_dst), .out_atomic_o(out_atomic),
        .rsp_retire_i(rsp_retire), .rsp_id_i(rsp_id));

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit rv, int id, int dst, bit at, bit ordy, bit ret, int rid);
        bit allowed;
        req_valid = rv; req_id = ID_W'(id); req_dst = DST_W'(dst); req_atomic = at;
        out_ready = ordy; rsp_retire = ret; rsp_id = ID_W'(rid);
        #1;
        allowed = at || mcnt[id] == 0 || (mdst[id] == dst && mcnt[id] < CNT_MAX);
        chk(tag, int'(out_valid), int'(rv && allowed), "out_valid");
        chk(tag, int'(req_ready), int'(ordy && allowed), "req_ready");
        if (rv) begin
            chk(tag, int'(out_id), id, "out_id");
            chk(tag, int'(out_dst), dst, "out_dst");
            chk(tag, int'(out_atomic), int'(at), "out_atomic");
        end
        @(posedge clk);
        if (rv && ordy && allowed && !at) begin
            mcnt[id]++;
            mdst[id] = dst;
        end
        if (ret) mcnt[rid]--;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NI; i++) begin mcnt[i] = 0; mdst[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle output, every ID free for every destination
        step("R1", 0, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < NI; i++)
            for (int d = 0; d < ND; d++)
                step("R1", 1, i, d, 0, 0, 0, 0);

        for (int id = 0; id < NI; id++) begin
            for (int d = 0; d < ND; d++) begin
                int od, oid;
                od  = (d + 1) % ND;
                oid = (id + 1) % NI;
                for (int k = 0; k < CNT_MAX; k++) step("R3", 1, id, d, 0, 1, 0, 0);
                step("R6", 1, id, d, 0, 1, 0, 0);
                step("R4", 1, id, od, 0, 1, 0, 0);
                step("R2", 1, oid, od, 0, 0, 0, 0);
                step("R5", 1, id, od, 1, 1, 0, 0);
                step("R5", 1, id, od, 0, 1, 0, 0);
                step("R7", 0, 0, 0, 0, 0, 1, id);
                step("R8", 1, id, d, 0, 1, 1, id);
                step("R8", 1, id, d, 0, 1, 0, 0);
                step("R8", 1, id, d, 0, 1, 0, 0);
                for (int k = 0; k < CNT_MAX; k++) step("R7", 1, id, od, 0, 0, 1, id);
                step("R7", 1, id, od, 0, 0, 0, 0);
                step("R9", 1, id, od, 0, 0, 0, 0);
                step("R9", 1, id, od, 0, 1, 0, 0);
                step("R4", 1, id, d, 0, 1, 0, 0);
                step("R7", 0, 0, 0, 0, 0, 1, id);
                step("R7", 1, id, d, 0, 0, 0, 0);
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule